// File: doc/BRIEF.md
# Thermometer Scratchpad and Command Controller

This block is the memory and control command layer of a single-line temperature sensor. A lower protocol layer handles line timing and device selection. After selection it hands this block whole bytes written by the bus master, and it asks for one data bit each time the master issues a read slot. The first byte after a line reset is a command. The command decides what the following bytes and read slots mean: loading the alarm limits and the configuration, streaming the nine-byte scratchpad with its check byte, moving the limits and configuration to and from a backing store, starting a timed temperature conversion, or reporting how the sensor is powered.

A conversion samples the temperature input when a timer expires. The timer length depends on the selected resolution and is divided by a parameter. Before storing the sample, the block clears the low bits that the chosen resolution does not provide. It then compares the sign and integer part of the sample against the limits held in the backing store and drives the result on an alarm output. The analog sensor is outside this block.

Top module: `thermo_cmd_ctrl`

## Requirements
- R1: After `rst_n`, the scratchpad reads as follows: temperature 0550h, high limit 7Dh, low limit C9h, configuration 7Fh. The backing store holds the same limit and configuration values, and `alarm_o` is 0.
- R2: Command BEh streams scratchpad bytes 0..8 least significant bit first. Byte 0 is the temperature low byte, byte 1 the temperature high byte, byte 2 the high limit, byte 3 the low limit, byte 4 the configuration, and bytes 5..7 read as FFh. Every read slot after the 72nd bit returns 1.
- R3: Byte 8 of the stream is the serial CRC with polynomial x^8+x^5+x^4+1 and initial value 0, shifted least significant bit first over bytes 0..7.
- R4: Command 4Eh takes the next three bytes as the high limit, the low limit and the configuration. The scratchpad changes only when the third byte arrives. A line reset before that leaves bytes 2..4 unchanged, and further bytes are ignored.
- R5: Configuration bit 7 always reads 0 and bits 4..0 always read 1. Bits 6:5 hold the resolution: 00 = 9 bits, 01 = 10 bits, 10 = 11 bits, 11 = 12 bits.
- R6: Command 48h copies scratchpad bytes 2..4 into the backing store. Command B8h loads the backing store back into scratchpad bytes 2..4.
- R7: Command 44h starts a conversion that stays busy for (CONV_FULL_CYCLES/TIME_DIV) >> (3 - resolution code) cycles. Read slots after the command return 0 while the conversion is busy and 1 once it is done.
- R8: At the end of a conversion, `temp_i` is stored as the scratchpad temperature. The low 3, 2 or 1 bits are cleared for the 9-, 10- or 11-bit resolutions.
- R9: After each conversion, `alarm_o` is set when the signed value of temperature bits 11:4 is greater than the backing-store high limit or less than the backing-store low limit, and cleared otherwise. The scratchpad limits are not used.
- R10: After command B4h, each read slot returns 0 when `parasite_i` is 1 and 1 when it is 0.
- R11: Every read slot is answered with `tx_valid_o` exactly one cycle later. A line reset makes the next byte a command. After an unknown command or a finished command, read slots return 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| link_reset_i | input | 1 | Line reset seen by the lower layer; aborts the command |
| rx_valid_i | input | 1 | Byte written by the master is present |
| rx_byte_i | input | 8 | Written byte |
| rd_slot_i | input | 1 | Master issued a read slot |
| temp_i | input | 16 | Sensor value, two's complement, 1/16 degree units |
| parasite_i | input | 1 | 1 when powered from the data line |
| tx_valid_o | output | 1 | Answer bit for the previous read slot is valid |
| tx_bit_o | output | 1 | Answer bit |
| alarm_o | output | 1 | Alarm flag from the latest conversion |

## Verification
The bench builds the block with CONV_FULL_CYCLES = 187,500,000 and TIME_DIV = 250,000. This turns the full 12-bit conversion into 750 cycles and the 9-bit one into 93. With these values the bench can place read slots one cycle inside and a few cycles past the end of the busy window. It can also run conversions at all four resolutions in the same short run, including random temperatures and limits that exercise the signed alarm compare and the masking of low bits.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

    localparam logic [7:0] CMD_WRITE_SP = 8'h4E;
    localparam logic [7:0] CMD_READ_SP  = 8'hBE;
    localparam logic [7:0] CMD_COPY     = 8'h48;
    localparam logic [7:0] CMD_CONVERT  = 8'h44;
    localparam logic [7:0] CMD_RECALL   = 8'hB8;
    localparam logic [7:0] CMD_POWER    = 8'hB4;

    localparam int SP_BYTES   = 9;
    localparam int SP_BITS    = SP_BYTES * 8;
    localparam int CRC_BITS   = (SP_BYTES - 1) * 8;

    typedef enum logic [2:0] {
        M_CMD,
        M_WRITE,
        M_READ,
        M_CONV,
        M_POWER,
        M_IDLE
    } mode_e;

    // clear the bits a lower resolution does not deliver
    function automatic logic [15:0] temp_trunc(input logic [15:0] t, input logic [1:0] res);
        logic [15:0] r;
        case (res)
            2'd0:    r = {t[15:3], 3'b000};
            2'd1:    r = {t[15:2], 2'b00};
            2'd2:    r = {t[15:1], 1'b0};
            default: r = t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/thermo_crc8.sv
module thermo_crc8 #(
    parameter logic [7:0] POLY_REFL = 8'h8C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       shift_i,
    input  logic       bit_i,
    output logic [7:0] crc_o
);
    logic [7:0] crc_d, crc_q;
    logic       fb;

    always_comb begin
        crc_d = crc_q;
        fb    = crc_q[0] ^ bit_i;
        if (clear_i) begin
            crc_d = '0;
        end else if (shift_i) begin
            crc_d = (crc_q >> 1) ^ (fb ? POLY_REFL : 8'h00);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;

    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (crc_o == 8'h00));

endmodule

// File: rtl/thermo_conv_timer.sv
module thermo_conv_timer #(
    parameter int unsigned BASE_CYCLES = 750,
    localparam int unsigned CNT_W = $clog2(BASE_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] res_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] res_o
);
    localparam logic [CNT_W-1:0] LEN_9  = CNT_W'((BASE_CYCLES >> 3) - 1);
    localparam logic [CNT_W-1:0] LEN_10 = CNT_W'((BASE_CYCLES >> 2) - 1);
    localparam logic [CNT_W-1:0] LEN_11 = CNT_W'((BASE_CYCLES >> 1) - 1);
    localparam logic [CNT_W-1:0] LEN_12 = CNT_W'(BASE_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [1:0]       res;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy = 1'b1;
                s_d.res  = res_i;
                case (res_i)
                    2'd0:    s_d.cnt = LEN_9;
                    2'd1:    s_d.cnt = LEN_10;
                    2'd2:    s_d.cnt = LEN_11;
                    default: s_d.cnt = LEN_12;
                endcase
            end
        end else if (s_q.cnt == '0) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{busy: 1'b0, done: 1'b0, res: 2'b11, cnt: '0};
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign res_o  = s_q.res;

    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    a_r7_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

endmodule

// File: rtl/thermo_alarm_flag.sv
module thermo_alarm_flag (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       update_i,
    input  logic [7:0] temp_hi_i,
    input  logic [7:0] lim_hi_i,
    input  logic [7:0] lim_lo_i,
    output logic       alarm_o
);
    logic alarm_d, alarm_q;

    always_comb begin
        alarm_d = alarm_q;
        if (update_i) begin
            alarm_d = ($signed(temp_hi_i) > $signed(lim_hi_i)) ||
                      ($signed(temp_hi_i) < $signed(lim_lo_i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alarm_q <= 1'b0;
        else        alarm_q <= alarm_d;
    end

    assign alarm_o = alarm_q;

    a_r9_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !update_i |=> $stable(alarm_o));

endmodule

// File: rtl/thermo_cmd_ctrl.sv
module thermo_cmd_ctrl
    import thermo_pkg::*;
#(
    parameter int unsigned CONV_FULL_CYCLES = 187_500_000,
    parameter int unsigned TIME_DIV         = 1,
    parameter logic [7:0]  HI_INIT          = 8'h7D,
    parameter logic [7:0]  LO_INIT          = 8'hC9,
    parameter logic [1:0]  RES_INIT         = 2'b11,
    parameter logic [15:0] TEMP_INIT        = 16'h0550
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_reset_i,
    input  logic        rx_valid_i,
    input  logic [7:0]  rx_byte_i,
    input  logic        rd_slot_i,
    input  logic [15:0] temp_i,
    input  logic        parasite_i,
    output logic        tx_valid_o,
    output logic        tx_bit_o,
    output logic        alarm_o
);
    localparam int unsigned BASE_CYCLES = CONV_FULL_CYCLES / TIME_DIV;
    localparam logic [7:0]  CFG_INIT    = {1'b0, RES_INIT, 5'h1F};
    localparam int          CNT_BITS    = $clog2(SP_BITS + 1);

    typedef struct packed {
        mode_e               mode;
        logic [CNT_BITS-1:0] bitcnt;
        logic [1:0]          wr_idx;
        logic [7:0]          stg_hi;
        logic [7:0]          stg_lo;
        logic [15:0]         sp_temp;
        logic [7:0]          sp_hi;
        logic [7:0]          sp_lo;
        logic [7:0]          sp_cfg;
        logic [7:0]          bk_hi;
        logic [7:0]          bk_lo;
        logic [7:0]          bk_cfg;
        logic                tx_valid;
        logic                tx_bit;
    } ctl_t;

    ctl_t s_d, s_q;

    logic        crc_clear, crc_shift, crc_bit;
    logic [7:0]  crc_val;
    logic        conv_start, conv_busy, conv_done;
    logic [1:0]  conv_res;
    logic [15:0] temp_cut;
    logic [7:0]  cur_byte;
    logic        cur_bit;

    assign temp_cut = temp_trunc(temp_i, conv_res);

    // byte under the stream pointer
    always_comb begin
        case (s_q.bitcnt[CNT_BITS-1:3])
            4'd0:    cur_byte = s_q.sp_temp[7:0];
            4'd1:    cur_byte = s_q.sp_temp[15:8];
            4'd2:    cur_byte = s_q.sp_hi;
            4'd3:    cur_byte = s_q.sp_lo;
            4'd4:    cur_byte = s_q.sp_cfg;
            4'd8:    cur_byte = crc_val;
            default: cur_byte = 8'hFF;
        endcase
        cur_bit = cur_byte[s_q.bitcnt[2:0]];
    end

    always_comb begin
        s_d          = s_q;
        s_d.tx_valid = 1'b0;
        crc_clear    = 1'b0;
        crc_shift    = 1'b0;
        crc_bit      = 1'b0;
        conv_start   = 1'b0;

        if (rd_slot_i) begin
            s_d.tx_valid = 1'b1;
            s_d.tx_bit   = 1'b1;
            case (s_q.mode)
                M_READ: begin
                    if (s_q.bitcnt < CNT_BITS'(SP_BITS)) begin
                        s_d.tx_bit = cur_bit;
                        s_d.bitcnt = s_q.bitcnt + 1'b1;
                        if (s_q.bitcnt < CNT_BITS'(CRC_BITS)) begin
                            crc_shift = 1'b1;
                            crc_bit   = cur_bit;
                        end
                    end
                end
                M_CONV:  s_d.tx_bit = !conv_busy;
                M_POWER: s_d.tx_bit = !parasite_i;
                default: s_d.tx_bit = 1'b1;
            endcase
        end

        if (rx_valid_i) begin
            case (s_q.mode)
                M_CMD: begin
                    case (rx_byte_i)
                        CMD_WRITE_SP: begin
                            s_d.mode   = M_WRITE;
                            s_d.wr_idx = 2'd0;
                        end
                        CMD_READ_SP: begin
                            s_d.mode   = M_READ;
                            s_d.bitcnt = '0;
                            crc_clear  = 1'b1;
                        end
                        CMD_COPY: begin
                            s_d.bk_hi  = s_q.sp_hi;
                            s_d.bk_lo  = s_q.sp_lo;
                            s_d.bk_cfg = s_q.sp_cfg;
                            s_d.mode   = M_IDLE;
                        end
                        CMD_RECALL: begin
                            s_d.sp_hi  = s_q.bk_hi;
                            s_d.sp_lo  = s_q.bk_lo;
                            s_d.sp_cfg = s_q.bk_cfg;
                            s_d.mode   = M_IDLE;
                        end
                        CMD_CONVERT: begin
                            conv_start = 1'b1;
                            s_d.mode   = M_CONV;
                        end
                        CMD_POWER: s_d.mode = M_POWER;
                        default:   s_d.mode = M_IDLE;
                    endcase
                end
                M_WRITE: begin
                    case (s_q.wr_idx)
                        2'd0: begin
                            s_d.stg_hi = rx_byte_i;
                            s_d.wr_idx = 2'd1;
                        end
                        2'd1: begin
                            s_d.stg_lo = rx_byte_i;
                            s_d.wr_idx = 2'd2;
                        end
                        default: begin
                            s_d.sp_hi  = s_q.stg_hi;
                            s_d.sp_lo  = s_q.stg_lo;
                            s_d.sp_cfg = {1'b0, rx_byte_i[6:5], 5'h1F};
                            s_d.mode   = M_IDLE;
                        end
                    endcase
                end
                default: ;
            endcase
        end

        if (conv_done) begin
            s_d.sp_temp = temp_cut;
        end

        if (link_reset_i) begin
            s_d.mode   = M_CMD;
            s_d.wr_idx = 2'd0;
            s_d.bitcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: M_CMD, bitcnt: '0, wr_idx: 2'd0,
                     stg_hi: 8'h00, stg_lo: 8'h00, sp_temp: TEMP_INIT,
                     sp_hi: HI_INIT, sp_lo: LO_INIT, sp_cfg: CFG_INIT,
                     bk_hi: HI_INIT, bk_lo: LO_INIT, bk_cfg: CFG_INIT,
                     tx_valid: 1'b0, tx_bit: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    thermo_crc8 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (crc_clear),
        .shift_i (crc_shift),
        .bit_i   (crc_bit),
        .crc_o   (crc_val)
    );

    thermo_conv_timer #(
        .BASE_CYCLES (BASE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (conv_start),
        .res_i   (s_q.sp_cfg[6:5]),
        .busy_o  (conv_busy),
        .done_o  (conv_done),
        .res_o   (conv_res)
    );

    thermo_alarm_flag u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .update_i  (conv_done),
        .temp_hi_i (temp_cut[11:4]),
        .lim_hi_i  (s_q.bk_hi),
        .lim_lo_i  (s_q.bk_lo),
        .alarm_o   (alarm_o)
    );

    assign tx_valid_o = s_q.tx_valid;
    assign tx_bit_o   = s_q.tx_bit;

    a_r11_slot_answer: assert property (@(posedge clk) disable iff (!rst_n)
        rd_slot_i |=> tx_valid_o);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_slot_i |=> !tx_valid_o);
    a_r11_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        link_reset_i |=> (s_q.mode == M_CMD));
    a_r2_stream_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bitcnt <= CNT_BITS'(SP_BITS));
    a_r2_tail_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_slot_i && !link_reset_i && s_q.mode == M_READ && s_q.bitcnt == CNT_BITS'(SP_BITS))
        |=> tx_bit_o);
    a_r4_partial_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == M_WRITE && s_q.wr_idx != 2'd2) |=> $stable(s_q.sp_cfg));

endmodule

// File: tb/thermo_cmd_ctrl_tb.sv
module thermo_cmd_ctrl_tb_top;

    localparam int unsigned FULL = 187_500_000;
    localparam int unsigned DIV  = 250_000;
    localparam int unsigned BASE = FULL / DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_reset_i = 1'b0;
    logic        rx_valid_i = 1'b0;
    logic [7:0]  rx_byte_i = 8'h00;
    logic        rd_slot_i = 1'b0;
    logic [15:0] temp_i = 16'h0000;
    logic        parasite_i = 1'b0;
    logic        tx_valid_o, tx_bit_o, alarm_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    // bench model
    logic [15:0] m_temp;
    logic [7:0]  m_hi, m_lo, m_cfg, b_hi, b_lo, b_cfg;
    logic        m_alarm;

    always #2 clk = ~clk;

    thermo_cmd_ctrl #(
        .CONV_FULL_CYCLES (FULL),
        .TIME_DIV         (DIV)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_reset_i (link_reset_i),
        .rx_valid_i   (rx_valid_i),
        .rx_byte_i    (rx_byte_i),
        .rd_slot_i    (rd_slot_i),
        .temp_i       (temp_i),
        .parasite_i   (parasite_i),
        .tx_valid_o   (tx_valid_o),
        .tx_bit_o     (tx_bit_o),
        .alarm_o      (alarm_o)
    );

    function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic f = r[0] ^ b[i];
            r = (r >> 1) ^ (f ? 8'h8C : 8'h00);
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_byte(input int idx);
        logic [7:0] v;
        case (idx)
            0: v = m_temp[7:0];
            1: v = m_temp[15:8];
            2: v = m_hi;
            3: v = m_lo;
            4: v = m_cfg;
            default: v = 8'hFF;
        endcase
        return v;
    endfunction

    function automatic logic [15:0] exp_trunc(input logic [15:0] t, input logic [1:0] res);
        logic [15:0] m = 16'hFFFF << (3 - res);
        return t & m;
    endfunction

    function automatic logic exp_alarm(input logic [15:0] t);
        logic signed [7:0] t8 = t[11:4];
        return (t8 > $signed(b_hi)) || (t8 < $signed(b_lo));
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_rst();
        link_reset_i = 1'b1;
        @(negedge clk);
        link_reset_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid_i = 1'b1;
        rx_byte_i  = b;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic read_bit(output logic b, output logic v);
        rd_slot_i = 1'b1;
        @(negedge clk);
        rd_slot_i = 1'b0;
        b = tx_bit_o;
        v = tx_valid_o;
    endtask

    // R2 R3: stream the whole scratchpad and compare to the model
    task automatic check_sp(input string tag);
        logic [7:0] got, c;
        logic b, v;
        bit ok = 1'b1;
        c = 8'h00;
        bus_rst();
        send_byte(8'hBE);
        for (int i = 0; i < 9; i++) begin
            logic [7:0] e;
            for (int k = 0; k < 8; k++) begin
                read_bit(b, v);
                got[k] = b;
                if (!v) ok = 1'b0;
            end
            e = (i == 8) ? c : exp_byte(i);
            if (i < 8) c = crc_step(c, e);
            chk(got == e, $sformatf("%s R2/R3 byte%0d", tag, i), {24'h0, got}, {24'h0, e});
        end
        chk(ok, {tag, " R11 tx_valid per slot"}, 32'(ok), 1);
        read_bit(b, v);
        chk(b == 1'b1, {tag, " R2 tail ones"}, 32'(b), 1);
    endtask

    task automatic write_sp(input logic [7:0] h, input logic [7:0] l, input logic [7:0] cf);
        bus_rst();
        send_byte(8'h4E);
        send_byte(h);
        send_byte(l);
        send_byte(cf);
        m_hi = h; m_lo = l; m_cfg = {1'b0, cf[6:5], 5'h1F};
    endtask

    task automatic simple_cmd(input logic [7:0] c);
        bus_rst();
        send_byte(c);
        if (c == 8'h48) begin b_hi = m_hi; b_lo = m_lo; b_cfg = m_cfg; end
        if (c == 8'hB8) begin m_hi = b_hi; m_lo = b_lo; m_cfg = b_cfg; end
    endtask

    // R7 R8 R9: conversion with busy polling around the expected end
    task automatic convert(input logic [15:0] t, input bit timed);
        logic b, v;
        int len = int'(BASE >> (3 - int'(m_cfg[6:5])));
        temp_i = t;
        bus_rst();
        send_byte(8'h44);
        if (timed) begin
            idle(len - 2);
            read_bit(b, v);
            chk(b == 1'b0, "R7 busy before end", 32'(b), 0);
            idle(3);
            read_bit(b, v);
            chk(b == 1'b1, "R7 done after end", 32'(b), 1);
        end else begin
            idle(len + 3);
            read_bit(b, v);
            chk(b == 1'b1, "R7 done", 32'(b), 1);
        end
        m_temp  = exp_trunc(t, m_cfg[6:5]);
        m_alarm = exp_alarm(m_temp);
        chk(alarm_o == m_alarm, "R9 alarm", 32'(alarm_o), 32'(m_alarm));
    endtask

    initial begin : watchdog
        repeat (200_000) @(posedge clk);
        if (!done_flag) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic b, v;
        void'($urandom(32'd20240611));
        m_temp = 16'h0550; m_hi = 8'h7D; m_lo = 8'hC9; m_cfg = 8'h7F;
        b_hi = m_hi; b_lo = m_lo; b_cfg = m_cfg; m_alarm = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk(alarm_o == 1'b0, "R1 alarm after reset", 32'(alarm_o), 0);
        chk(tx_valid_o == 1'b0, "R11 no answer without slot", 32'(tx_valid_o), 0);
        check_sp("R1 reset");

        // R11 unknown command answers 1
        bus_rst();
        send_byte(8'h00);
        read_bit(b, v);
        chk(b && v, "R11 unknown cmd ones", {30'h0, v, b}, 3);

        // R4 R5 full write with masked configuration
        write_sp(8'h19, 8'h05, 8'hFF);
        send_byte(8'hAA);
        check_sp("R5 cfg mask");

        // R4 partial write discarded
        bus_rst();
        send_byte(8'h4E);
        send_byte(8'h33);
        send_byte(8'h44);
        check_sp("R4 partial");

        // R6 copy, overwrite, recall
        simple_cmd(8'h48);
        write_sp(8'h01, 8'h02, 8'h00);
        check_sp("R6 before recall");
        simple_cmd(8'hB8);
        check_sp("R6 recall");

        // R10 power mode
        parasite_i = 1'b1;
        bus_rst();
        send_byte(8'hB4);
        read_bit(b, v);
        chk(b == 1'b0, "R10 parasite", 32'(b), 0);
        parasite_i = 1'b0;
        read_bit(b, v);
        chk(b == 1'b1, "R10 external", 32'(b), 1);

        // R7 R8 9-bit conversion, backing limits 19h/05h
        write_sp(8'h19, 8'h05, 8'h1F);
        simple_cmd(8'h48);
        convert(16'h01A7, 1'b1);
        check_sp("R8 9-bit temp");
        // R9 above high limit (value 26 > 25)
        convert(16'h01A0, 1'b1);
        chk(alarm_o == 1'b1, "R9 high alarm", 32'(alarm_o), 1);
        // R9 scratch limits ignored: relax scratch only, alarm stays on backing
        write_sp(8'h7F, 8'h80, 8'h1F);
        convert(16'h01A0, 1'b0);
        chk(alarm_o == 1'b1, "R9 backing limits used", 32'(alarm_o), 1);
        // R9 negative below low limit
        simple_cmd(8'hB8);
        convert(16'hFF5E, 1'b0);
        chk(alarm_o == 1'b1, "R9 low alarm", 32'(alarm_o), 1);
        convert(16'h0100, 1'b0);
        chk(alarm_o == 1'b0, "R9 alarm clears", 32'(alarm_o), 0);

        // random rounds over all resolutions
        for (int r = 0; r < 10; r++) begin
            logic [7:0] h = 8'($urandom);
            logic [7:0] l = 8'($urandom);
            logic [7:0] cf = 8'($urandom);
            logic [11:0] t12 = 12'($urandom);
            write_sp(h, l, cf);
            simple_cmd(8'h48);
            convert({{4{t12[11]}}, t12}, (r % 3) == 0);
            check_sp($sformatf("rand%0d", r));
        end

        done_flag = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule